// File: doc/BRIEF.md
# Pretrigger Acquisition Sequencer

This block steers a digitizer while it captures one waveform record into a circular acquisition memory of 1024 locations. A start command latches the wanted pretrigger depth. The sequencer then writes that many samples before it raises the trigger-arm output. Trigger events that arrive before the depth is filled are dropped. After an accepted trigger it writes exactly the remaining samples of the record and then raises done. It also keeps the memory address of the first sample written after the trigger, so that software can later rotate the circular record into time order.

Sample timing comes from a decimating clock-enable generator. It passes one of every (decim+1) incoming sample strobes. A free-running calibrator square wave is produced beside it. The memory write port (enable and address) is driven from registers, so a block RAM can sit directly behind it.

Top module: `acq_seq_top`

## Requirements
- R1: During and right after reset, wr_en, trig_arm and done are 0, trig_addr is 0 and cal_clk is 0; the first write after reset goes to address 0.
- R2: start is acted on only when the sequencer is idle or done, and it latches pre_cnt at that moment; a start during an acquisition has no effect.
- R3: trig_arm goes to 1 only after exactly pre_cnt samples have been written since the accepted start; with pre_cnt = 0 it is 1 in the cycle after start.
- R4: A trigger while filling the pretrigger depth, while idle or while done is discarded: it is not stored and does not begin the post-trigger phase.
- R5: From the accepted trigger, exactly 1024 - pre_cnt samples are written and then done rises. A sample accepted in the same cycle as the trigger counts as the first post-trigger sample.
- R6: trig_addr takes the write address of the first post-trigger sample and holds it until the next trigger is accepted.
- R7: Each write goes to the address one above the previous write, wrapping from 1023 to 0. A new start does not reset the address.
- R8: wr_en pulses with wr_addr valid in the cycle after samp_ce is 1 while filling, armed or post-trigger; there are no writes while idle or done.
- R9: samp_ce is 1 for one cycle following every (decim+1)-th sample strobe, counted from reset or from the last accepted start.
- R10: cal_clk toggles every CAL_HALF clock cycles (25 by default).
- R11: done stays 1 from completion until the next accepted start, and trig_arm is 0 whenever done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new record acquisition |
| pre_cnt | input | 10 | Pretrigger sample count, 0 to 1023 |
| decim | input | 8 | Strobe decimation: one sample per decim+1 strobes |
| smp_stb | input | 1 | Raw sample strobe from the converter side |
| trig | input | 1 | Trigger event pulse |
| samp_ce | output | 1 | Decimated sample clock enable |
| wr_en | output | 1 | Acquisition memory write enable |
| wr_addr | output | 10 | Acquisition memory write address |
| trig_arm | output | 1 | Trigger circuit may accept a trigger |
| done | output | 1 | Record complete |
| trig_addr | output | 10 | Address of the first post-trigger sample |
| cal_clk | output | 1 | Calibrator square wave |

## Verification
The assertions watch properties that hold in every cycle: consecutive writes step the address by one with wraparound, a trigger during the fill never starts the post-trigger phase, no write occurs once done has settled, trig_arm and done never overlap, and trig_addr moves only while armed or post-trigger. The exact pretrigger and post-trigger counts, the trigger address value, the same-cycle trigger case, zero-depth arming and the decimation ratio can only be shown by the bench's scenarios. There, a reference model predicts every write address and the final trigger position.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4
  } acq_state_e;
endpackage

// File: rtl/acq_rate_gen.sv
module acq_rate_gen #(
  parameter int DEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             stb,
  input  logic [DEC_W-1:0] decim,
  output logic             ce
);
  logic [DEC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      ce  <= 1'b0;
    end else begin
      ce <= 1'b0;
      if (stb) begin
        if (cnt == decim) begin
          cnt <= '0;
          ce  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/acq_cal_gen.sv
module acq_cal_gen #(
  parameter int CAL_HALF = 25
) (
  input  logic clk,
  input  logic rst,
  output logic cal_clk
);
  localparam int CW = (CAL_HALF < 2) ? 1 : $clog2(CAL_HALF);

  generate
    if (CAL_HALF < 2) begin : g_fast
      always_ff @(posedge clk) begin
        if (rst) cal_clk <= 1'b0;
        else     cal_clk <= ~cal_clk;
      end
    end else begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt     <= '0;
          cal_clk <= 1'b0;
        end else if (cnt == CW'(CAL_HALF - 1)) begin
          cnt     <= '0;
          cal_clk <= ~cal_clk;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] pre_cnt,
  input  logic              ce,
  input  logic              trig,
  output logic              launch,
  output acq_state_e        state,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              trig_arm,
  output logic              done,
  output logic [ADDR_W-1:0] trig_addr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] pre_q;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W-1:0]  post_len;
  logic [CNT_W-1:0]  cur;
  logic              need_ta;
  logic              active;
  logic              acc;
  logic              post_hit;

  assign launch   = start && (state == ST_IDLE || state == ST_DONE);
  assign active   = (state == ST_FILL) || (state == ST_ARMED) || (state == ST_POST);
  assign acc      = ce && active;
  assign post_hit = acc && ((state == ST_POST) || (state == ST_ARMED && trig));
  assign post_len = CNT_W'(DEPTH) - {1'b0, pre_q};
  assign cur      = (state == ST_ARMED) ? post_len : rem;
  assign trig_arm = (state == ST_ARMED);
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      pre_q     <= '0;
      rem       <= '0;
      need_ta   <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      trig_addr <= '0;
    end else begin
      wr_en <= acc;
      if (acc) begin
        wr_addr <= ptr;
        ptr     <= ptr + 1'b1;
      end

      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            pre_q <= pre_cnt;
            rem   <= {1'b0, pre_cnt};
            state <= (pre_cnt == '0) ? ST_ARMED : ST_FILL;
          end
        end
        ST_FILL: begin
          if (acc) begin
            rem <= rem - 1'b1;
            if (rem == CNT_W'(1)) state <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (trig) begin
            state   <= ST_POST;
            rem     <= post_len;
            need_ta <= 1'b1;
          end
        end
        default: ;
      endcase

      if (post_hit) begin
        if (state == ST_ARMED || need_ta) trig_addr <= ptr;
        need_ta <= 1'b0;
        if (cur == CNT_W'(1)) state <= ST_DONE;
        else                  rem   <= cur - 1'b1;
      end
    end
  end
endmodule

// File: rtl/acq_seq_top.sv
module acq_seq_top
  import acq_seq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DEC_W    = 8,
  parameter int CAL_HALF = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] pre_cnt,
  input  logic [DEC_W-1:0]  decim,
  input  logic              smp_stb,
  input  logic              trig,
  output logic              samp_ce,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              trig_arm,
  output logic              done,
  output logic [ADDR_W-1:0] trig_addr,
  output logic              cal_clk
);
  logic       launch;
  acq_state_e state;

  acq_rate_gen #(.DEC_W(DEC_W)) u_rate (
    .clk   (clk),
    .rst   (rst),
    .clear (launch),
    .stb   (smp_stb),
    .decim (decim),
    .ce    (samp_ce)
  );

  acq_cal_gen #(.CAL_HALF(CAL_HALF)) u_cal (
    .clk     (clk),
    .rst     (rst),
    .cal_clk (cal_clk)
  );

  acq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pre_cnt   (pre_cnt),
    .ce        (samp_ce),
    .trig      (trig),
    .launch    (launch),
    .state     (state),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .trig_arm  (trig_arm),
    .done      (done),
    .trig_addr (trig_addr)
  );
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk
  import acq_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              trig,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              trig_arm,
  input logic              done,
  input logic [ADDR_W-1:0] trig_addr,
  input acq_state_e        state
);
  logic              have_w;
  logic [ADDR_W-1:0] last_a;
  logic [ADDR_W-1:0] next_a;

  assign next_a = last_a + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_w <= 1'b0;
      last_a <= '0;
    end else if (wr_en) begin
      have_w <= 1'b1;
      last_a <= wr_addr;
    end
  end

  p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && have_w) |-> (wr_addr == next_a));

  p_fill_trig_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL && trig) |=> (state != ST_POST));

  p_no_write_done_r8: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> !wr_en);

  p_arm_done_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(trig_arm && done));

  p_last_write_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> wr_en);

  p_taddr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !($past(state) == ST_ARMED || $past(state) == ST_POST) |-> $stable(trig_addr));
endmodule

bind acq_seq_top acq_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig      (trig),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .trig_arm  (trig_arm),
  .done      (done),
  .trig_addr (trig_addr),
  .state     (state)
);

// File: tb/tb_acq_seq_top.sv
`timescale 1ns/1ps
module tb_acq_seq_top;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int CALH = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] pre_cnt = '0;
  logic [7:0] decim = '0;
  logic smp_stb = 1'b0;
  logic trig = 1'b0;
  logic samp_ce, wr_en, trig_arm, done, cal_clk;
  logic [AW-1:0] wr_addr, trig_addr;

  always #2 clk = ~clk;

  acq_seq_top #(.ADDR_W(AW), .DEC_W(8), .CAL_HALF(CALH)) dut (
    .clk(clk), .rst(rst), .start(start), .pre_cnt(pre_cnt), .decim(decim),
    .smp_stb(smp_stb), .trig(trig), .samp_ce(samp_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .trig_arm(trig_arm), .done(done),
    .trig_addr(trig_addr), .cal_clk(cal_clk)
  );

  int checks = 0;
  int fails = 0;
  int ce_seen = 0;
  bit finished = 1'b0;
  logic [AW-1:0] expq[$];

  // reference model: 0 idle, 1 fill, 2 armed, 3 post, 4 done
  int ms = 0, mptr = 0, mrem = 0, mpre = 0, mta = 0, mdec = 0, mscnt = 0;
  bit mneed = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (samp_ce) ce_seen++;
      if (wr_en) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R8 unexpected write", int'(wr_addr), -1);
        end else begin
          logic [AW-1:0] e;
          e = expq.pop_front();
          chk(wr_addr == e, "R7 write address", int'(wr_addr), int'(e));
        end
      end
    end
  end

  task automatic post_step(input bit act);
    if (act && mneed) begin mta = mptr; mneed = 1'b0; end
    if (act) begin mrem--; if (mrem == 0) ms = 4; end
  endtask

  task automatic sample(input bit with_trig);
    bit acc, act;
    @(negedge clk);
    smp_stb = 1'b1;
    acc = (mscnt == mdec);
    mscnt = acc ? 0 : mscnt + 1;
    act = acc && ms >= 1 && ms <= 3;
    if (act) expq.push_back(AW'(mptr));
    if (ms == 1) begin
      if (act) begin mrem--; if (mrem == 0) ms = 2; end
    end else if (ms == 2 && with_trig) begin
      ms = 3; mneed = 1'b1; mrem = DEPTH - mpre;
      post_step(act);
    end else if (ms == 3) begin
      post_step(act);
    end
    if (act) mptr = (mptr + 1) % DEPTH;
    @(negedge clk);
    smp_stb = 1'b0;
    trig = with_trig;
    @(negedge clk);
    trig = 1'b0;
    @(negedge clk);
  endtask

  task automatic trig_only();
    @(negedge clk);
    trig = 1'b1;
    if (ms == 2) begin ms = 3; mneed = 1'b1; mrem = DEPTH - mpre; end
    @(negedge clk);
    trig = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_start(input int pre, input int dec);
    @(negedge clk);
    pre_cnt = AW'(pre);
    decim = 8'(dec);
    start = 1'b1;
    if (ms == 0 || ms == 4) begin
      ms = (pre == 0) ? 2 : 1;
      mpre = pre; mrem = pre; mscnt = 0; mdec = dec;
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_record(input string rq);
    int guard = 0;
    while (ms != 4 && guard < 5000) begin
      sample(1'b0);
      guard++;
    end
    chk(done == 1'b1, rq, int'(done), 1);
    chk(trig_addr == AW'(mta), "R6 trigger address", int'(trig_addr), mta);
    chk(trig_arm == 1'b0, "R11 arm low when done", int'(trig_arm), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int c0, n;
    repeat (5) @(negedge clk);
    chk(wr_en == 1'b0 && trig_arm == 1'b0 && done == 1'b0, "R1 reset outputs",
        int'({wr_en, trig_arm, done}), 0);
    chk(cal_clk == 1'b0, "R10 calibrator reset", int'(cal_clk), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(trig_addr == '0, "R1 trig_addr reset", int'(trig_addr), 0);

    // idle: strobes and a trigger produce no writes (R8, R4)
    sample(1'b0);
    sample(1'b1);
    chk(done == 1'b0 && trig_arm == 1'b0, "R4 idle trigger ignored", int'(done), 0);

    // calibrator period R10
    while (cal_clk == 1'b0) @(negedge clk);
    n = 0;
    while (cal_clk == 1'b1) begin @(negedge clk); n++; end
    chk(n == CALH, "R10 calibrator half period", n, CALH);

    // Scenario A: pre 4, trigger during fill discarded
    do_start(4, 0);
    chk(trig_arm == 1'b0, "R3 not armed at start", int'(trig_arm), 0);
    sample(1'b0);
    sample(1'b1);
    sample(1'b0);
    chk(trig_arm == 1'b0, "R3 not armed after 3 of 4", int'(trig_arm), 0);
    sample(1'b0);
    chk(trig_arm == 1'b1, "R4 fill trigger dropped, R3 armed after 4", int'(trig_arm), 1);
    do_start(7, 0);
    chk(trig_arm == 1'b1, "R2 start while armed ignored", int'(trig_arm), 1);
    sample(1'b0); sample(1'b0); sample(1'b0);
    trig_only();
    chk(trig_arm == 1'b0, "R5 post phase after trigger", int'(trig_arm), 0);
    finish_record("R5 done after 1024-pre post samples");
    sample(1'b0);
    chk(done == 1'b1, "R11 done holds", int'(done), 1);

    // Scenario B: pre 1020, trigger coincides with a sample, wraps address
    do_start(1020, 0);
    chk(done == 1'b0, "R11 done cleared by start", int'(done), 0);
    n = 0;
    while (ms == 1 && n < 2000) begin sample(1'b0); n++; end
    chk(n == 1020, "R3 fill length", n, 1020);
    chk(trig_arm == 1'b1, "R3 armed after 1020", int'(trig_arm), 1);
    sample(1'b1);
    chk(mta == (4 + 3 + 1020 + 1020) % DEPTH, "R5 same-cycle sample is first post", mta,
        (4 + 3 + 1020 + 1020) % DEPTH);
    finish_record("R5 done after 4 post samples");

    // Scenario C: pre 0, decimation by 3
    do_start(0, 2);
    chk(trig_arm == 1'b1, "R3 zero depth arms at once", int'(trig_arm), 1);
    c0 = ce_seen;
    for (int i = 0; i < 6; i++) sample(1'b0);
    chk(ce_seen - c0 == 2, "R9 one enable per three strobes", ce_seen - c0, 2);
    trig_only();
    finish_record("R5 done after full post record");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R8 all expected writes seen", expq.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule